// File: doc/BRIEF.md
# UART Interrupt Priority and Status Unit

This block gathers every interrupt cause of a single UART channel and selects the most urgent one that is pending. It presents the result as an 8-bit interrupt status value. Bit 0 of that value is an active-low pending flag. Bits [5:1] identify the winning cause. Bits [7:6] mirror the FIFO enable.

Causes that arrive as one-cycle event pulses are held in latches. A latch clears when software performs the read that services its cause. The two receive-data causes are not latched; they follow level conditions supplied by the receive FIFO.

Two extended causes come after the classic five: a flow-control character match and a flow-control pin change. They only take part when the enhanced-feature enable is high. An Xoff match stays pending until an Xon character is seen.

The status value is combinational, so a read of the status register samples it during the read cycle. Any clear caused by that read takes effect at the following clock edge.

Top module: `uart_irq_prio`

## Requirements
- R1: After reset, with the FIFO enable low and all inputs low, the status reads 0x01.
- R2: When several causes are pending, the reported cause is the first in this order: line status, receive ready, receive time-out, transmit empty, modem status, character match, pin change.
- R3: Status bits [5:0] read as follows for each cause:
  - line status 000110
  - receive ready 000100
  - receive time-out 001100
  - transmit empty 000010
  - modem status 000000
  - character match 010000
  - pin change 100000
  - nothing pending 000001
- R4: Bit 0 is 0 whenever any cause is pending and 1 otherwise.
- R5: With the enhanced-feature enable low, character-match and pin-change causes are masked, so bits [5:4] read 0. Their latches keep their state and reappear when the enable returns high.
- R6: An Xoff match keeps the character-match cause pending across status register reads until an Xon match pulse is received.
- R7: A line-status event latches its cause. A line status register read clears it.
- R8: Receive ready and receive time-out follow their level inputs. No register read changes them.
- R9: Transmit-empty and character-match event latches clear on a status register read.
- R10: Modem-status and pin-change latches clear on a modem status register read.
- R11: Bits [7:6] both equal the FIFO enable input.
- R12: If an event pulse and its clearing read occur in the same cycle, the cause is pending after the edge.
- R13: During a status register read cycle the status still shows the cause being read. The clear appears only after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ls_evt | input | 1 | Line status error event pulse |
| rx_rdy_lvl | input | 1 | Receive FIFO at or above trigger level |
| rx_tmo_lvl | input | 1 | Receive time-out condition level |
| thr_evt | input | 1 | Transmit holding empty event pulse |
| msr_evt | input | 1 | Modem input change event pulse |
| xoff_evt | input | 1 | Xoff character match pulse |
| xon_evt | input | 1 | Xon character match pulse |
| spc_evt | input | 1 | Special character match pulse |
| pin_evt | input | 1 | Flow-control pin change pulse |
| isr_rd | input | 1 | Interrupt status register read strobe |
| lsr_rd | input | 1 | Line status register read strobe |
| msr_rd | input | 1 | Modem status register read strobe |
| enh_en | input | 1 | Enhanced-feature enable |
| fifo_en | input | 1 | FIFO enable |
| irq_status | output | 8 | Interrupt status value |

## Verification
The bench uses seeded random traffic in which event pulses, level conditions and the three read strobes occur independently. This produces many overlaps of pending causes, which tests the priority order and encodings. It also produces random collisions of events with their clearing reads, which separates set-wins behaviour from clear-wins behaviour.

Directed sequences cover the rest:
- An Xoff match followed by repeated status reads and then an Xon match distinguishes the sticky hold from an ordinary event latch.
- Toggling the enhanced-feature enable over a pending pin change confirms that masking does not lose the latch.
- Reads issued while only a level cause is active show that receive causes ignore read strobes.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NUM_SRC  = 7;
  localparam int NUM_EDGE = 5;

  typedef enum logic [2:0] {
    SRC_LS    = 3'd0,
    SRC_RXRDY = 3'd1,
    SRC_RXTMO = 3'd2,
    SRC_THR   = 3'd3,
    SRC_MSR   = 3'd4,
    SRC_CHR   = 3'd5,
    SRC_PIN   = 3'd6,
    SRC_NONE  = 3'd7
  } src_e;

  // status bits [5:0] for a chosen cause
  function automatic logic [5:0] src_code(src_e s);
    case (s)
      SRC_LS:    return 6'b000110;
      SRC_RXRDY: return 6'b000100;
      SRC_RXTMO: return 6'b001100;
      SRC_THR:   return 6'b000010;
      SRC_MSR:   return 6'b000000;
      SRC_CHR:   return 6'b010000;
      SRC_PIN:   return 6'b100000;
      default:   return 6'b000001;
    endcase
  endfunction
endpackage

// File: rtl/irq_src_latch.sv
module irq_src_latch #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q_o[i] <= 1'b0;
      else if (set_i[i]) q_o[i] <= 1'b1;
      else if (clr_i[i]) q_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
  import uart_irq_pkg::*;
#(
  parameter int N = NUM_SRC
) (
  input  logic [N-1:0] req_i,
  output src_e         sel_o
);
  // walk from lowest to highest so the highest pending wins
  always_comb begin
    sel_o = SRC_NONE;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) sel_o = src_e'(i[2:0]);
    end
  end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ls_evt,
  input  logic       rx_rdy_lvl,
  input  logic       rx_tmo_lvl,
  input  logic       thr_evt,
  input  logic       msr_evt,
  input  logic       xoff_evt,
  input  logic       xon_evt,
  input  logic       spc_evt,
  input  logic       pin_evt,
  input  logic       isr_rd,
  input  logic       lsr_rd,
  input  logic       msr_rd,
  input  logic       enh_en,
  input  logic       fifo_en,
  output logic [7:0] irq_status
);
  localparam int E_LS = 0, E_THR = 1, E_MSR = 2, E_CHR = 3, E_PIN = 4;

  logic [NUM_EDGE-1:0] edge_set, edge_clr, edge_q;
  logic                xoff_hold;
  logic [NUM_SRC-1:0]  req;
  src_e                win;
  logic                any_pend;

  always_comb begin
    edge_set        = '0;
    edge_clr        = '0;
    edge_set[E_LS]  = ls_evt;
    edge_clr[E_LS]  = lsr_rd;
    edge_set[E_THR] = thr_evt;
    edge_clr[E_THR] = isr_rd;
    edge_set[E_MSR] = msr_evt;
    edge_clr[E_MSR] = msr_rd;
    edge_set[E_CHR] = xoff_evt | xon_evt | spc_evt;
    edge_clr[E_CHR] = isr_rd;
    edge_set[E_PIN] = pin_evt;
    edge_clr[E_PIN] = msr_rd;
  end

  irq_src_latch #(.W(NUM_EDGE)) u_lat (
    .clk(clk), .rst_n(rst_n), .set_i(edge_set), .clr_i(edge_clr), .q_o(edge_q)
  );

  // Xoff keeps the match cause alive until an Xon arrives
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        xoff_hold <= 1'b0;
    else if (xoff_evt) xoff_hold <= 1'b1;
    else if (xon_evt)  xoff_hold <= 1'b0;
  end

  always_comb begin
    req            = '0;
    req[SRC_LS]    = edge_q[E_LS];
    req[SRC_RXRDY] = rx_rdy_lvl;
    req[SRC_RXTMO] = rx_tmo_lvl;
    req[SRC_THR]   = edge_q[E_THR];
    req[SRC_MSR]   = edge_q[E_MSR];
    req[SRC_CHR]   = enh_en & (edge_q[E_CHR] | xoff_hold);
    req[SRC_PIN]   = enh_en & edge_q[E_PIN];
  end

  irq_prio_sel #(.N(NUM_SRC)) u_sel (.req_i(req), .sel_o(win));

  assign any_pend   = (win != SRC_NONE);
  assign irq_status = {fifo_en, fifo_en, src_code(win)};

  // R4
  pend_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_status[0] == (req == '0));
  // R12
  ls_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ls_evt |=> irq_status[3:0] == 4'b0110);
  // R7
  ls_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !ls_evt) |=> !edge_q[E_LS]);
  // R5
  enh_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enh_en |-> irq_status[5:4] == 2'b00);
  // R6
  xoff_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xoff_hold && !xon_evt) |=> xoff_hold);
  // R11
  fifo_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_status[7:6] == {2{fifo_en}});
  // R2
  onehot_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_pend |-> req[win]);
endmodule

// File: tb/uart_irq_prio_test.sv
`timescale 1ns/1ps
module uart_irq_prio_test;
  logic clk = 0, rst_n = 0;
  logic ls_evt = 0, rx_rdy_lvl = 0, rx_tmo_lvl = 0, thr_evt = 0, msr_evt = 0;
  logic xoff_evt = 0, xon_evt = 0, spc_evt = 0, pin_evt = 0;
  logic isr_rd = 0, lsr_rd = 0, msr_rd = 0, enh_en = 0, fifo_en = 0;
  logic [7:0] irq_status;

  int tests = 0, fails = 0;
  logic m_ls = 0, m_thr = 0, m_msr = 0, m_chr = 0, m_pin = 0, m_xoff = 0;

  always #5 clk = ~clk;

  uart_irq_prio uut (.*);

  // expected status from the requirement tables
  function automatic logic [7:0] exp_status();
    logic [5:0] c;
    if (m_ls)                         c = 6'b000110;
    else if (rx_rdy_lvl)              c = 6'b000100;
    else if (rx_tmo_lvl)              c = 6'b001100;
    else if (m_thr)                   c = 6'b000010;
    else if (m_msr)                   c = 6'b000000;
    else if (enh_en && (m_chr || m_xoff)) c = 6'b010000;
    else if (enh_en && m_pin)         c = 6'b100000;
    else                              c = 6'b000001;
    return {fifo_en, fifo_en, c};
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // one cycle: compare, take the edge, advance the model, drop pulses
  task automatic tick(string req);
    #1 check(req, irq_status, exp_status());
    @(posedge clk); #1;
    m_ls   = ls_evt ? 1'b1 : (lsr_rd ? 1'b0 : m_ls);
    m_thr  = thr_evt ? 1'b1 : (isr_rd ? 1'b0 : m_thr);
    m_msr  = msr_evt ? 1'b1 : (msr_rd ? 1'b0 : m_msr);
    m_chr  = (xoff_evt | xon_evt | spc_evt) ? 1'b1 : (isr_rd ? 1'b0 : m_chr);
    m_pin  = pin_evt ? 1'b1 : (msr_rd ? 1'b0 : m_pin);
    m_xoff = xoff_evt ? 1'b1 : (xon_evt ? 1'b0 : m_xoff);
    @(negedge clk);
    {ls_evt, thr_evt, msr_evt, xoff_evt, xon_evt, spc_evt, pin_evt} = '0;
    {isr_rd, lsr_rd, msr_rd} = '0;
  endtask

  initial begin
    #2000000;
    fails++; tests++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #1 check("R1 reset", irq_status, 8'h01);
    @(negedge clk); @(negedge clk); rst_n = 1;
    check("R1 after reset", irq_status, 8'h01);
    fifo_en = 1; #1 check("R11 fifo bits", irq_status, 8'hC1);
    enh_en = 1;

    // R12 collision of event and clearing read
    ls_evt = 1; lsr_rd = 1; tick("R12");
    check("R12 set wins", irq_status, 8'hC6);
    // R7 line status read clears
    lsr_rd = 1; tick("R7");
    check("R7 cleared", irq_status, 8'hC1);
    // R13 transmit empty visible during read, gone after edge
    thr_evt = 1; tick("R9");
    isr_rd = 1; #1 check("R13 during read", irq_status, 8'hC2);
    tick("R13");
    check("R9 thr cleared", irq_status, 8'hC1);
    // R6 xoff sticky across status reads
    xoff_evt = 1; tick("R6");
    for (int i = 0; i < 3; i++) begin isr_rd = 1; tick("R6"); end
    check("R6 sticky", irq_status, 8'hD0);
    xon_evt = 1; tick("R6");
    isr_rd = 1; tick("R9");
    check("R6 released", irq_status, 8'hC1);
    // R5 masking keeps latch
    pin_evt = 1; tick("R5");
    enh_en = 0; #1 check("R5 masked", irq_status, 8'hC1);
    tick("R5");
    enh_en = 1; #1 check("R5 restored", irq_status, 8'hE0);
    // R10 modem read clears modem and pin
    msr_evt = 1; tick("R10");
    check("R10 msr pending", irq_status, 8'hC0);
    msr_rd = 1; tick("R10");
    check("R10 cleared", irq_status, 8'hC1);
    // R8 levels ignore reads
    rx_tmo_lvl = 1; isr_rd = 1; lsr_rd = 1; msr_rd = 1; tick("R8");
    check("R8 timeout held", irq_status, 8'hCC);
    rx_rdy_lvl = 1; isr_rd = 1; tick("R8");
    check("R2 ready over timeout", irq_status, 8'hC4);
    rx_rdy_lvl = 0; rx_tmo_lvl = 0; tick("R8");

    // random mix (R2 R3 R4 R9 R10 R12)
    for (int n = 0; n < 3000; n++) begin
      ls_evt     = ($urandom % 16) == 0;
      thr_evt    = ($urandom % 8) == 0;
      msr_evt    = ($urandom % 10) == 0;
      xoff_evt   = ($urandom % 20) == 0;
      xon_evt    = ($urandom % 20) == 0;
      spc_evt    = ($urandom % 20) == 0;
      pin_evt    = ($urandom % 10) == 0;
      isr_rd     = ($urandom % 4) == 0;
      lsr_rd     = ($urandom % 4) == 0;
      msr_rd     = ($urandom % 4) == 0;
      if ($urandom % 8 == 0) rx_rdy_lvl = $urandom;
      if ($urandom % 8 == 0) rx_tmo_lvl = $urandom;
      if ($urandom % 32 == 0) enh_en = $urandom;
      if ($urandom % 64 == 0) fifo_en = $urandom;
      tick("R2 R3 R4");
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule